// File: doc/BRIEF.md
# Vsync-Relative Coast Window Generator

This block produces the coast signal that tells a line-locked clock-recovery loop to stop following its horizontal sync reference around the vertical sync interval, where sync pulses may be missing, doubled or distorted. Coast has to begin before the vertical sync arrives, so the block does not just react to vertical sync. It counts horizontal sync strobes between consecutive vertical sync strobes, keeps that frame length, and predicts when the next vertical sync is due. Coast rises a programmed number of lines ahead of the predicted vertical sync. It falls a programmed number of lines after the vertical sync that actually arrives.

The sync inputs are single-cycle strobes in the block's clock domain. They have already been cleaned up upstream, and the two strobes never fall in the same cycle. A source select can hand the output over to an externally supplied coast level instead. That external level is asynchronous, so it passes through a two-flop synchronizer and a polarity control before it reaches the output. The recommended setting for typical sources is two lines of precoast and ten lines of postcoast.

Top module: `coast_window_gen`

## Requirements
- R1: After reset the coast output is low, no frame length is known, and no vertical sync has been seen.
- R2: With the internal source selected (src_ext = 0), a vsync strobe drives coast high from the cycle after the strobe.
- R3: The postcoast count Q is taken at each vsync strobe. Coast stays high through the first Q hsync strobes after that vsync and is released by hsync number Q+1 (unless the precoast window holds it). With Q = 0, the first hsync after vsync releases coast.
- R4: The number of hsync strobes between two consecutive vsync strobes is latched as the frame length at the second strobe. Until one such full frame has been measured, only the postcoast window is produced.
- R5: With a measured frame length F and a precoast value P of 1 or more, coast rises on the hsync strobe that brings the line count since the last vsync to F − P. This masks the last P hsyncs before the predicted vsync. With P = 0 there is no precoast window, so coast starts at the vsync strobe itself.
- R6: If vsync arrives later than predicted, coast stays high on every line past the predicted point until the vsync strobe arrives.
- R7: If vsync arrives earlier than predicted, coast is asserted in the next cycle, the postcoast count starts from that vsync, and the shorter count becomes the new frame length.
- R8: With src_ext = 1, coast follows only the external coast input, and hsync and vsync strobes have no effect on it. Returning to src_ext = 0 restores the internal window, which kept tracking the frame the whole time.
- R9: The external coast input is resynchronized by two flops: a change becomes visible on coast after the second rising clock edge that follows it, not after the first.
- R10: ext_low_active = 1 treats a low external input as coast active (coast = NOT synchronized input); ext_low_active = 0 passes the synchronized level through as is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_stb | input | 1 | One-cycle strobe per horizontal sync leading edge |
| vsync_stb | input | 1 | One-cycle strobe per vertical sync leading edge |
| pre_lines | input | REG_W (8) | Lines of coast before the predicted vsync |
| post_lines | input | REG_W (8) | Lines of coast after vsync |
| src_ext | input | 1 | 0 selects the internal window, 1 the external input |
| ext_coast_in | input | 1 | Asynchronous external coast level |
| ext_low_active | input | 1 | 1 makes the external input active low |
| coast | output | 1 | Coast request to the clock-recovery loop |

## Verification
The bench sweeps frame lengths, precoast and postcoast values, and compares coast after every strobe with a line-position formula. A design that counted one line too many or too few would open or close the window one hsync off. A design that had no zero-value exception would mask an extra line before vsync, or miss the release at the first hsync. Frames longer and shorter than predicted check that a late vsync keeps coast held and that an early one forces coast at once and re-measures. The external path is sampled one and two edges after each change, which exposes a missing or extra synchronizer stage and an inverted polarity, and strobes sent in external mode show any leak of the internal window.

// File: rtl/coast_pkg.sv
package coast_pkg;
  localparam int DEF_LINE_W      = 11;
  localparam int DEF_REG_W       = 8;
  localparam int DEF_SYNC_STAGES = 2;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/coast_sync.sv
module coast_sync #(
  parameter int STAGES = coast_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stg_d[k] = d;
    end else begin : g_next
      assign stg_d[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/coast_line_meter.sv
module coast_line_meter #(
  parameter int LINE_W = coast_pkg::DEF_LINE_W,
  parameter int REG_W  = coast_pkg::DEF_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_stb,
  input  logic              vs_stb,
  input  logic [REG_W-1:0]  pre_lines,
  output logic              pre_win,
  output logic [LINE_W-1:0] line_cnt,
  output logic [LINE_W-1:0] frame_len,
  output logic              meas_valid
);
  localparam int SUM_W = coast_pkg::max_w(LINE_W, REG_W) + 1;
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] line_q, line_d;
  logic [LINE_W-1:0] len_q, len_d;
  logic              seen_q, seen_d;
  logic              valid_q, valid_d;
  logic              upd_en;
  logic [SUM_W-1:0]  reach_sum;

  assign upd_en = hs_stb | vs_stb;

  always_comb begin
    line_d  = line_q;
    len_d   = len_q;
    seen_d  = seen_q;
    valid_d = valid_q;
    if (vs_stb) begin
      line_d = '0;
      seen_d = 1'b1;
      if (seen_q) begin
        len_d   = line_q;
        valid_d = 1'b1;
      end
    end else if (hs_stb && (line_q != CNT_MAX)) begin
      line_d = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      len_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (upd_en) begin
      line_q  <= line_d;
      len_q   <= len_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  assign reach_sum = SUM_W'(line_q) + SUM_W'(pre_lines);

  always_comb begin
    pre_win = valid_q && (pre_lines != '0) && (reach_sum >= SUM_W'(len_q));
  end

  assign line_cnt   = line_q;
  assign frame_len  = len_q;
  assign meas_valid = valid_q;
endmodule

// File: rtl/coast_post_timer.sv
module coast_post_timer #(
  parameter int REG_W = coast_pkg::DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_stb,
  input  logic             vs_stb,
  input  logic [REG_W-1:0] post_lines,
  output logic             post_act,
  output logic [REG_W-1:0] post_cnt
);
  logic             act_q, act_d;
  logic [REG_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign upd_en = vs_stb | (hs_stb & act_q);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (vs_stb) begin
      act_d = 1'b1;
      cnt_d = post_lines;
    end else if (hs_stb && act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign post_act = act_q;
  assign post_cnt = cnt_q;
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen #(
  parameter int LINE_W      = coast_pkg::DEF_LINE_W,
  parameter int REG_W       = coast_pkg::DEF_REG_W,
  parameter int SYNC_STAGES = coast_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_stb,
  input  logic             vsync_stb,
  input  logic [REG_W-1:0] pre_lines,
  input  logic [REG_W-1:0] post_lines,
  input  logic             src_ext,
  input  logic             ext_coast_in,
  input  logic             ext_low_active,
  output logic             coast
);
  logic              core_rst_n;
  logic              ext_sync;
  logic              ext_level;
  logic              pre_win;
  logic              post_act;
  logic [REG_W-1:0]  post_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] frame_len;
  logic              meas_valid;
  logic              int_coast;

  // reset: asserted at once, released on the clock
  coast_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (core_rst_n)
  );

  coast_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
    .clk    (clk),
    .arst_n (core_rst_n),
    .d      (ext_coast_in),
    .q      (ext_sync)
  );

  coast_line_meter #(.LINE_W(LINE_W), .REG_W(REG_W)) i_meter (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .hs_stb     (hsync_stb),
    .vs_stb     (vsync_stb),
    .pre_lines  (pre_lines),
    .pre_win    (pre_win),
    .line_cnt   (line_cnt),
    .frame_len  (frame_len),
    .meas_valid (meas_valid)
  );

  coast_post_timer #(.REG_W(REG_W)) i_post (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .hs_stb     (hsync_stb),
    .vs_stb     (vsync_stb),
    .post_lines (post_lines),
    .post_act   (post_act),
    .post_cnt   (post_cnt)
  );

  assign ext_level = ext_sync ^ ext_low_active;
  assign int_coast = pre_win | post_act;
  assign coast     = src_ext ? ext_level : int_coast;
endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk #(
  parameter int LINE_W = coast_pkg::DEF_LINE_W,
  parameter int REG_W  = coast_pkg::DEF_REG_W
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              hsync_stb,
  input logic              vsync_stb,
  input logic [REG_W-1:0]  pre_lines,
  input logic              src_ext,
  input logic              ext_coast_in,
  input logic              ext_low_active,
  input logic              coast,
  input logic              pre_win,
  input logic              post_act,
  input logic [REG_W-1:0]  post_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] frame_len,
  input logic              meas_valid
);
  logic [1:0] settle_q;
  logic       settled;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)            settle_q <= '0;
    else if (settle_q != 2'd3)  settle_q <= settle_q + 2'd1;
  end
  assign settled = (settle_q == 2'd3);

  a_r2_vsync_opens: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!src_ext && vsync_stb) |=> (src_ext || coast));

  a_r3_post_release: assert property (@(posedge clk) disable iff (!core_rst_n)
    (post_act && (post_cnt == '0) && hsync_stb && !vsync_stb) |=> !post_act);

  a_r3_post_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (post_act && (post_cnt != '0) && hsync_stb && !vsync_stb) |=> post_act);

  a_r4_frame_latch: assert property (@(posedge clk) disable iff (!core_rst_n)
    (vsync_stb && meas_valid) |=> (frame_len == $past(line_cnt)));

  a_r5_pre_persists: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pre_win && !vsync_stb) |=> (pre_win || (pre_lines != $past(pre_lines))));

  a_r9_ext_two_flops: assert property (@(posedge clk) disable iff (!core_rst_n)
    (settled && src_ext) |-> (coast == ($past(ext_coast_in, 2) ^ ext_low_active)));
endmodule

bind coast_window_gen coast_window_chk #(.LINE_W(LINE_W), .REG_W(REG_W)) i_chk (
  .clk            (clk),
  .core_rst_n     (core_rst_n),
  .hsync_stb      (hsync_stb),
  .vsync_stb      (vsync_stb),
  .pre_lines      (pre_lines),
  .src_ext        (src_ext),
  .ext_coast_in   (ext_coast_in),
  .ext_low_active (ext_low_active),
  .coast          (coast),
  .pre_win        (pre_win),
  .post_act       (post_act),
  .post_cnt       (post_cnt),
  .line_cnt       (line_cnt),
  .frame_len      (frame_len),
  .meas_valid     (meas_valid)
);

// File: tb/test_coast_window_gen.sv
module test_coast_window_gen;
  localparam int LW = 11;
  localparam int RW = 8;

  logic clk;
  logic rst_n;
  logic hsync_stb, vsync_stb;
  logic src_ext, ext_coast_in, ext_low_active;
  logic coast;
  int   pre_v, post_v;

  int n_chk, n_err;
  int m_len, m_cnt, m_q;
  bit m_seen, m_valid, m_ext;
  bit done;

  coast_window_gen #(.LINE_W(LW), .REG_W(RW)) i_coast_window_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .hsync_stb      (hsync_stb),
    .vsync_stb      (vsync_stb),
    .pre_lines      (RW'(pre_v)),
    .post_lines     (RW'(post_v)),
    .src_ext        (src_ext),
    .ext_coast_in   (ext_coast_in),
    .ext_low_active (ext_low_active),
    .coast          (coast)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit exp_int();
    bit post_on, pre_on;
    post_on = m_seen && (m_cnt <= m_q);
    pre_on  = m_valid && (pre_v != 0) && (m_cnt + pre_v >= m_len);
    return post_on || pre_on;
  endfunction

  function automatic bit exp_now();
    return src_ext ? m_ext : exp_int();
  endfunction

  task automatic check(input string req, input bit exp);
    n_chk++;
    if (coast !== exp) begin
      n_err++;
      $display("FAIL %s: coast=%0b expected=%0b (line %0d len %0d pre %0d post %0d)",
               req, coast, exp, m_cnt, m_len, pre_v, m_q);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hs_pulse(input string req);
    hsync_stb = 1'b1;
    @(negedge clk);
    hsync_stb = 1'b0;
    m_cnt++;
    check(req, exp_now());
    idle(3);
  endtask

  task automatic vs_pulse(input string req);
    vsync_stb = 1'b1;
    @(negedge clk);
    vsync_stb = 1'b0;
    if (m_seen) begin
      m_len   = m_cnt;
      m_valid = 1'b1;
    end
    m_seen = 1'b1;
    m_cnt  = 0;
    m_q    = post_v;
    check(req, exp_now());
    idle(3);
  endtask

  task automatic frame(input int n, input string hreq, input string vreq);
    repeat (n) hs_pulse(hreq);
    vs_pulse(vreq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    m_len = 0; m_cnt = 0; m_q = 0;
    m_seen = 1'b0; m_valid = 1'b0; m_ext = 1'b0;
    rst_n = 1'b0; hsync_stb = 1'b0; vsync_stb = 1'b0;
    src_ext = 1'b0; ext_coast_in = 1'b0; ext_low_active = 1'b0;
    pre_v = 2; post_v = 3;
    idle(3);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    idle(5);
    check("R1 after reset", 1'b0);

    // lines before any vsync, then first frame without a measurement
    frame(5, "R1 no vsync yet", "R2");
    frame(8, "R4 unmeasured", "R2");

    // sweep frame length, precoast and postcoast
    for (int f = 6; f <= 9; f++) begin
      for (int p = 0; p <= 5; p++) begin
        for (int q = 0; q <= 3; q++) begin
          pre_v  = p;
          post_v = q;
          frame(f, "R3/R5 sweep", "R2");
        end
      end
    end

    // precoast zero: nothing masked before vsync, postcoast zero
    pre_v = 0; post_v = 0;
    frame(6, "R5 zero precoast", "R2");
    frame(6, "R5 zero precoast", "R3 zero postcoast");

    // late vsync
    pre_v = 2; post_v = 1;
    frame(7, "R4", "R2");
    frame(7, "R5", "R2");
    frame(11, "R6 late vsync", "R6");
    // early vsync, then frame re-measured to the short count
    frame(4, "R7", "R7 early vsync");
    frame(7, "R7 relearned", "R2");
    frame(7, "R7", "R2");

    // external source
    src_ext = 1'b1; ext_low_active = 1'b0; ext_coast_in = 1'b0; m_ext = 1'b0;
    idle(4);
    check("R8 external idle", 1'b0);
    frame(6, "R8 hsync ignored", "R8 vsync ignored");
    ext_coast_in = 1'b1;
    @(negedge clk);
    check("R9 one edge", 1'b0);
    @(negedge clk);
    check("R9 two edges", 1'b1);
    m_ext = 1'b1;
    hs_pulse("R8 hsync ignored");
    ext_low_active = 1'b1;
    #1;
    check("R10 active low inactive", 1'b0);
    m_ext = 1'b0;
    @(negedge clk);
    ext_coast_in = 1'b0;
    @(negedge clk);
    check("R9 one edge low", 1'b0);
    @(negedge clk);
    check("R10 active low asserted", 1'b1);
    m_ext = 1'b1;
    vs_pulse("R8 vsync ignored");
    ext_low_active = 1'b0;
    #1;
    check("R10 active high", 1'b0);
    m_ext = 1'b0;

    // back to the internal window, which kept tracking
    @(negedge clk);
    src_ext = 1'b0;
    #1;
    check("R8 return internal", exp_int());
    @(negedge clk);
    frame(7, "R8 internal again", "R2");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule